// File: doc/BRIEF.md
# Wide-Word CRC-32 Engine

This block computes a 32-bit cyclic redundancy check over a packet that arrives as a sequence of wide words, one word per clock. Each accepted word advances the checksum by as many bit positions as the word has bits. The result is exactly the one a one-bit-per-clock linear feedback shift register would reach after taking the same bits in stream order. Bit 0 of each word is the earliest bit of the stream. The generator is 0x04C11DB7, processed MSB-first in the register, so feedback is taken from register bit 31.

The work is a single linear map over GF(2). Both the running register and the incoming word multiply a constant binary matrix, and the two products are combined by XOR. The matrix columns are worked out at elaboration by a package function that runs the serial update for each unit vector, so no generated tables or outside tools are needed. A packet begins with a word flagged as first, which seeds the register with all ones. It ends with a word flagged as final, whose result is presented bit-inverted together with a one-cycle completion pulse.

Top module: `crc_par_engine`

## Requirements
- R1: After reset, `crc_q` is 0 and `crc_fin` is 0. The running register holds 0xFFFFFFFF, so a first word sent without `pkt_sop` gives the same result as one sent with it.
- R2: One accepted word gives the same register value as DATA_W serial steps. Each step uses bit `word_i[k]` for k = 0 up to DATA_W-1 in turn. A step is fb = reg[31] ^ bit, then reg = (reg << 1) ^ (fb ? 0x04C11DB7 : 0).
- R3: An accepted word with `pkt_sop` high starts from 0xFFFFFFFF, whatever state the previous packet left behind.
- R4: An accepted word with `pkt_eop` high makes `crc_q` show the bitwise inverse of the updated register one cycle later, with `crc_fin` high for exactly that one cycle.
- R5: An accepted word with `pkt_eop` low makes `crc_q` show the updated register uninverted one cycle later, with `crc_fin` low.
- R6: In a cycle with `word_vld` low, the register, `crc_q` and `crc_fin` are left alone: `crc_q` holds and `crc_fin` is low. `pkt_sop` and `pkt_eop` have no effect in such a cycle.
- R7: Across a packet of several words, the final result equals the serial computation over the words concatenated in arrival order.
- R8: At DATA_W = 8, take the nine ASCII bytes "123456789" and present each byte with its most significant bit on `word_i[0]`. The final `crc_q` is then 0xFC891918.
- R9: DATA_W must be a nonzero multiple of 8, otherwise elaboration fails. Results hold at widths 8, 32 and 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | The word on `word_i` is accepted this cycle |
| pkt_sop | input | 1 | Accepted word is the first of a packet (reseed) |
| pkt_eop | input | 1 | Accepted word is the last of a packet (invert, flag) |
| word_i | input | DATA_W | Data word, bit 0 earliest in stream order |
| crc_q | output | 32 | Checksum after the most recent accepted word |
| crc_fin | output | 1 | One-cycle pulse: `crc_q` holds a finished packet result |

## Verification
The riskiest corner is bit ordering inside a word. A matrix built with the stream reversed still gives a stable, plausible checksum, but it disagrees with the per-bit reference and with the known "123456789" answer on the very first word. Reseeding partway through is driven by opening a new packet right after an unfinished one; an engine that ignored the first-word flag would carry stale state forward. Idle cycles carry stray first and last flags. A design that decoded those flags without qualifying them by valid would reseed or pulse completion with no data. The same stimulus drives three widths, so a column generator that is right only at one width shows up as a mismatch at the others.

// File: rtl/crc_par_pkg.sv
package crc_par_pkg;
   localparam int CRC_W = 32;
   typedef logic [CRC_W-1:0] crc_t;

   // one serial LFSR step, MSB-first feedback
   function automatic crc_t crc_bit_step(crc_t poly, crc_t c, logic b);
      logic fb;
      fb = c[CRC_W-1] ^ b;
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
      return c;
   endfunction

   // effect on the register of a lone 1 at word bit idx, zero start state
   function automatic crc_t crc_data_col(crc_t poly, int unsigned w, int unsigned idx);
      crc_t c;
      c = '0;
      for (int unsigned s = 0; s < w; s++) c = crc_bit_step(poly, c, (s == idx));
      return c;
   endfunction

   // effect of register bit idx after w zero-data steps
   function automatic crc_t crc_state_col(crc_t poly, int unsigned w, int unsigned idx);
      crc_t c;
      c = '0;
      c[idx] = 1'b1;
      for (int unsigned s = 0; s < w; s++) c = crc_bit_step(poly, c, 1'b0);
      return c;
   endfunction
endpackage

// File: rtl/crc_par_matrix.sv
module crc_par_matrix
   import crc_par_pkg::*;
#(
   parameter int   DATA_W = 64,
   parameter crc_t POLY   = 32'h04C11DB7
) (
   input  crc_t              cur,
   input  logic [DATA_W-1:0] data,
   output crc_t              nxt
);
   crc_t dcol [DATA_W];
   crc_t scol [CRC_W];

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_dcol
      localparam crc_t COL = crc_data_col(POLY, DATA_W, gi);
      assign dcol[gi] = COL;
   end

   for (genvar gj = 0; gj < CRC_W; gj++) begin : g_scol
      localparam crc_t COL = crc_state_col(POLY, DATA_W, gj);
      assign scol[gj] = COL;
   end

   always_comb begin
      crc_t acc;
      acc = '0;
      for (int i = 0; i < DATA_W; i++) acc = acc ^ (dcol[i] & {CRC_W{data[i]}});
      for (int j = 0; j < CRC_W; j++)  acc = acc ^ (scol[j] & {CRC_W{cur[j]}});
      nxt = acc;
   end
endmodule

// File: rtl/crc_par_state.sv
module crc_par_state
   import crc_par_pkg::*;
#(
   parameter crc_t SEED = 32'hFFFFFFFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld,
   input  logic sop,
   input  logic eop,
   input  crc_t nxt,
   output crc_t base,
   output crc_t res_q,
   output logic fin_q
);
   crc_t run_q;

   assign base = sop ? SEED : run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= SEED;
         res_q <= '0;
         fin_q <= 1'b0;
      end else begin
         fin_q <= vld & eop;
         if (vld) begin
            run_q <= nxt;
            res_q <= eop ? ~nxt : nxt;
         end
      end
   end
endmodule

// File: rtl/crc_par_engine.sv
module crc_par_engine
   import crc_par_pkg::*;
#(
   parameter int   DATA_W = 64,
   parameter crc_t POLY   = 32'h04C11DB7,
   parameter crc_t SEED   = 32'hFFFFFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  logic              pkt_sop,
   input  logic              pkt_eop,
   input  logic [DATA_W-1:0] word_i,
   output logic [31:0]       crc_q,
   output logic              crc_fin
);
   localparam int BYTES = DATA_W / 8;

   // R9: width legality
   if (DATA_W < 8 || BYTES * 8 != DATA_W) begin : g_bad_width
      $error("crc_par_engine: DATA_W must be a nonzero multiple of 8");
   end

   crc_t base, nxt;

   crc_par_matrix #(.DATA_W(DATA_W), .POLY(POLY)) u_matrix (
      .cur (base),
      .data(word_i),
      .nxt (nxt)
   );

   crc_par_state #(.SEED(SEED)) u_state (
      .clk  (clk),
      .rst_n(rst_n),
      .vld  (word_vld),
      .sop  (pkt_sop),
      .eop  (pkt_eop),
      .nxt  (nxt),
      .base (base),
      .res_q(crc_q),
      .fin_q(crc_fin)
   );
endmodule

// File: rtl/crc_par_engine_chk.sv
module crc_par_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        word_vld,
   input logic        pkt_eop,
   input logic [31:0] crc_q,
   input logic        crc_fin
);
   a_r4_fin_follows_eop: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && pkt_eop) |=> crc_fin);

   a_r4_fin_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      crc_fin |-> $past(word_vld && pkt_eop));

   a_r5_no_fin_midpacket: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !pkt_eop) |=> !crc_fin);

   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(crc_q) && !crc_fin));
endmodule

bind crc_par_engine crc_par_engine_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .word_vld(word_vld),
   .pkt_eop (pkt_eop),
   .crc_q   (crc_q),
   .crc_fin (crc_fin)
);

// File: tb/crc_par_engine_bench.sv
`timescale 1ns/1ps
module crc_par_engine_bench;
   localparam logic [31:0] GEN  = 32'h04C11DB7;
   localparam logic [31:0] INIT = 32'hFFFFFFFF;
   localparam logic [7:0]  KAT [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                       8'h36, 8'h37, 8'h38, 8'h39};
   localparam logic [31:0] KAT_RES = 32'hFC891918;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0, sop = 1'b0, eop = 1'b0;
   logic [511:0] dbus = '0;
   logic [31:0] q8, q32, q512;
   logic f8, f32, f512;
   int nchk = 0, nfail = 0;

   // models
   logic [31:0] m8 = INIT, m32 = INIT, m512 = INIT;
   logic [31:0] o8 = '0, o32 = '0, o512 = '0;
   logic        edone = 1'b0;

   always #10 clk = ~clk;

   crc_par_engine #(.DATA_W(8))   u_crc_par_engine (.clk(clk), .rst_n(rst_n), .word_vld(vld),
      .pkt_sop(sop), .pkt_eop(eop), .word_i(dbus[7:0]), .crc_q(q8), .crc_fin(f8));
   crc_par_engine #(.DATA_W(32))  u_crc_par_engine_w32 (.clk(clk), .rst_n(rst_n), .word_vld(vld),
      .pkt_sop(sop), .pkt_eop(eop), .word_i(dbus[31:0]), .crc_q(q32), .crc_fin(f32));
   crc_par_engine #(.DATA_W(512)) u_crc_par_engine_w512 (.clk(clk), .rst_n(rst_n), .word_vld(vld),
      .pkt_sop(sop), .pkt_eop(eop), .word_i(dbus), .crc_q(q512), .crc_fin(f512));

   function automatic logic [31:0] ser(logic [31:0] c, logic [511:0] d, int w);
      for (int s = 0; s < w; s++) begin
         logic fb;
         fb = c[31] ^ d[s];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ GEN;
      end
      return c;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "crc w8",   q8,   o8);
      chk(req, "crc w32",  q32,  o32);
      chk(req, "crc w512", q512, o512);
      chk(req, "fin w8",   {31'b0, f8},   {31'b0, edone});
      chk(req, "fin w32",  {31'b0, f32},  {31'b0, edone});
      chk(req, "fin w512", {31'b0, f512}, {31'b0, edone});
   endtask

   // called at a falling edge; result checked at the next falling edge
   task automatic push(string req, logic [511:0] d, logic v, logic s, logic l);
      logic [31:0] n8, n32, n512;
      dbus = d; vld = v; sop = s; eop = l;
      if (v) begin
         n8   = ser(s ? INIT : m8,   d, 8);
         n32  = ser(s ? INIT : m32,  d, 32);
         n512 = ser(s ? INIT : m512, d, 512);
         m8 = n8; m32 = n32; m512 = n512;
         o8   = l ? ~n8   : n8;
         o32  = l ? ~n32  : n32;
         o512 = l ? ~n512 : n512;
         edone = l;
      end else begin
         edone = 1'b0;
      end
      @(negedge clk);
      check_all(req);
   endtask

   function automatic logic [511:0] rnd_word();
      logic [511:0] r;
      for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
      return r;
   endfunction

   function automatic logic [7:0] rev8(logic [7:0] b);
      for (int k = 0; k < 8; k++) rev8[k] = b[7-k];
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");                        // reset state
      // R1: first word without sop uses the reset seed
      push("R1", rnd_word(), 1'b1, 1'b0, 1'b0);
      push("R5", rnd_word(), 1'b1, 1'b0, 1'b1);
      push("R4", '0, 1'b0, 1'b0, 1'b0);       // fin drops after one cycle

      // R8: known-answer table walked at width 8 (others tracked by model)
      for (int i = 0; i < 9; i++)
         push("R8", {504'b0, rev8(KAT[i])}, 1'b1, (i == 0), (i == 8));
      chk("R8", "kat result", q8, KAT_RES);
      push("R6", rnd_word(), 1'b0, 1'b1, 1'b1); // stray flags, valid low

      // R3: reseed in the middle of an unfinished packet
      push("R7", rnd_word(), 1'b1, 1'b1, 1'b0);
      push("R7", rnd_word(), 1'b1, 1'b0, 1'b0);
      push("R3", rnd_word(), 1'b1, 1'b1, 1'b0);
      push("R3", rnd_word(), 1'b1, 1'b0, 1'b1);
      // R2: all-zero and all-one single-word packets
      push("R2", '0, 1'b1, 1'b1, 1'b1);
      push("R2", '1, 1'b1, 1'b1, 1'b1);

      // R7 / R2 / R9: random packets, random lengths, idle gaps with stray flags
      for (int p = 0; p < 60; p++) begin
         int len;
         len = 1 + int'($urandom % 6);
         for (int w = 0; w < len; w++) begin
            push("R7", rnd_word(), 1'b1, (w == 0), (w == len - 1));
            if (($urandom % 4) == 0)
               push("R6", rnd_word(), 1'b0, 1'($urandom), 1'($urandom));
         end
      end
      vld = 1'b0; sop = 1'b0; eop = 1'b0;
      summary();
      $finish;
   end
endmodule